// File: doc/BRIEF.md
# Tiled Display-Memory Host Port

This block is the host-facing side of a display memory that holds a 240 x 160 image of two-bit pixels. Four pixels share one byte, and the lowest bit pair of a byte holds the leftmost pixel. Up to four identical chips can sit on one shared bus. Each chip watches a common 17-bit address space, and a two-bit position code together with a direction pin tells the chip which quarter of the combined panel it owns. When an access falls in its own tile, the chip turns the host row and byte column into a word address of its local 16-bit memory. It then works out which byte lanes take part, runs one cycle on the memory port and answers through a ready line.

The memory has a single port, and the display refresh side reads it with fixed priority. While the display holds the memory, the host request waits and ready stays low. The request is served in the first cycle the display leaves free. The top sixteen bus addresses do not reach the memory: they write the four-entry grey-level palette of one chip of the group. The pads are outside the block, so every tri-state output appears as a value plus an enable.

Top module: `tdr_host_if`

## Requirements
- R1: With the direction pin at 0, bit 0 of the position code picks the row half (rows 0–159 when 0, rows 160–319 when 1), and bit 1 picks the column half (bytes 0–59 when 0, bytes 60–119 when 1). Host address bits 16..8 are the row and bits 7..0 are the byte column.
- R2: With the direction pin at 1, the two position bits swap roles: bit 1 picks the row half and bit 0 picks the column half.
- R3: An access in the tile uses local word (row − row base) × 30 + (column − column base) / 2. Bit 0 of the address selects the upper byte of that word. Pixel data passes through unchanged, so the first pixel stays in bits 1..0.
- R4: In 16-bit mode, the lanes follow byte-enable-low and A0. Byte enable 0 with A0 0 uses both bytes. Byte enable 0 with A0 1 uses only the upper byte. Byte enable 1 with A0 0 uses only the lower byte. Byte enable 1 with A0 1 starts no access.
- R5: In 8-bit mode, data moves only on bus bits 7..0, and A0 picks the byte inside the word. The byte enable and bus bits 15..8 are ignored, and read data is never driven on the upper lane.
- R6: With chip select high, or with both read and write high, the block starts no memory cycle and leaves ready released.
- R7: An access outside this chip's tile leaves ready released, drives no data lanes and starts no memory cycle.
- R8: No memory cycle is issued in a cycle where the display holds the memory. If the display holds it for N cycles counted from the cycle the strobe arrives, the reply is delayed by N − 1 clocks (by none when N is 0 or 1).
- R9: Without contention, ready rises at the second clock edge after the strobe for a write and at the third for a read.
- R10: A write to 0x1FFF0–0x1FFFF whose address bits 3..2 equal the inverted position code pulses the palette write for one cycle. The pulse carries index = address bits 1..0 and the five low bits of the active byte lane. It starts no memory cycle, and ready rises at the second edge. A palette address for another position gets no reply.
- R11: Once ready is high, it stays high with stable read data until the host drops its strobe. Ready and the data lanes are released one clock after the strobe is dropped.
- R12: After reset, ready is released, no data lanes are driven and no memory cycle is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 17 | Host byte address |
| host_wdata | input | 16 | Host write data |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ube_n | input | 1 | Upper byte enable, active low (16-bit mode) |
| bus8 | input | 1 | 1 = 8-bit host bus, 0 = 16-bit |
| pos | input | 2 | Position code of this chip in the group |
| dir | input | 1 | Panel orientation, swaps the role of the position bits |
| rd_data | output | 16 | Read data value |
| rd_lane_oe | output | 2 | Drive enable per byte lane of rd_data |
| rdy | output | 1 | Ready value, 1 = access complete |
| rdy_oe | output | 1 | Drive enable of the ready line |
| disp_busy | input | 1 | Display side holds the memory this cycle |
| ram_en | output | 1 | Memory cycle strobe |
| ram_we | output | 1 | Memory write |
| ram_addr | output | 13 | Memory word address |
| ram_be | output | 2 | Memory byte enables |
| ram_wdata | output | 16 | Memory write data |
| ram_rdata | input | 16 | Memory read data, valid the cycle after ram_en |
| pal_we | output | 1 | Palette write pulse |
| pal_idx | output | 2 | Palette entry index |
| pal_data | output | 5 | Palette entry value |

## Verification
The assertions take for granted that the host behaves: it keeps address, lanes, mode and strobe steady from the strobe's first cycle until it sees ready. It never asserts read and write together, and it only drops the strobe after ready or when no reply can come. The memory's read data is assumed valid one cycle after the strobe. The stimulus drives every transfer through one task that applies all host inputs on a falling edge and holds them until ready or a timeout. It then releases everything together. The display-busy input is raised only for a counted number of cycles that begin with the strobe, and a behavioural memory answers with a one-cycle read latency.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_CAPT = 3'd2,
        ST_PAL  = 3'd3,
        ST_DONE = 3'd4
    } st_e;
endpackage

// File: rtl/tdr_tile_decode.sv
module tdr_tile_decode #(
    parameter int ROWS = 160,
    parameter int COLB = 60,
    parameter int HAW  = 17,
    parameter int RAW  = 13
) (
    input  logic [HAW-1:0] addr,
    input  logic [1:0]     pos,
    input  logic           dir,
    output logic           tile_hit,
    output logic [RAW-1:0] word_addr,
    output logic           pal_hit,
    output logic [1:0]     pal_idx
);
    localparam int RW  = HAW - 8;
    localparam int WPR = COLB / 2;
    localparam logic [HAW-5:0] PAL_TAG = '1;

    logic [RW-1:0] row, row_base, row_loc;
    logic [7:0]    col, col_base, col_loc;
    logic          row_up, col_up;

    always_comb begin
        row      = addr[HAW-1:8];
        col      = addr[7:0];
        row_up   = dir ? pos[1] : pos[0];
        col_up   = dir ? pos[0] : pos[1];
        row_base = row_up ? RW'(ROWS) : '0;
        col_base = col_up ? 8'(COLB) : '0;
        row_loc  = row - row_base;
        col_loc  = col - col_base;
        tile_hit = (row >= row_base) && (row_loc < RW'(ROWS)) &&
                   (col >= col_base) && (col_loc < 8'(COLB));
        word_addr = RAW'(row_loc) * RAW'(WPR) + RAW'(col_loc >> 1);
        pal_hit  = (addr[HAW-1:4] == PAL_TAG) && (addr[3:2] == ~pos);
        pal_idx  = addr[1:0];
    end
endmodule

// File: rtl/tdr_lane_steer.sv
module tdr_lane_steer #(
    parameter int DW = 16,
    parameter int PW = 5
) (
    input  logic          bus8,
    input  logic          a0,
    input  logic          ube_n,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rword,
    output logic [1:0]    ram_be,
    output logic [1:0]    bus_lanes,
    output logic [DW-1:0] ram_wdata,
    output logic [DW-1:0] rd_data,
    output logic [PW-1:0] pal_data
);
    localparam int BW = DW / 2;

    always_comb begin
        if (bus8) begin
            ram_be    = a0 ? 2'b10 : 2'b01;
            bus_lanes = 2'b01;
            ram_wdata = {wdata[BW-1:0], wdata[BW-1:0]};
            rd_data   = {{BW{1'b0}}, (a0 ? rword[DW-1:BW] : rword[BW-1:0])};
        end else begin
            ram_be    = {~ube_n, ~a0};
            bus_lanes = {~ube_n, ~a0};
            ram_wdata = wdata;
            rd_data   = rword;
        end
        pal_data = (bus8 || !a0) ? wdata[PW-1:0] : wdata[BW+PW-1:BW];
    end
endmodule

// File: rtl/tdr_host_if.sv
module tdr_host_if #(
    parameter int ROWS = 160,
    parameter int COLB = 60,
    parameter int HAW  = 17,
    parameter int DW   = 16,
    parameter int PW   = 5,
    localparam int RAW = $clog2(ROWS * COLB / 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    input  logic           cs_n,
    input  logic           oe_n,
    input  logic           we_n,
    input  logic           ube_n,
    input  logic           bus8,
    input  logic [1:0]     pos,
    input  logic           dir,
    output logic [DW-1:0]  rd_data,
    output logic [1:0]     rd_lane_oe,
    output logic           rdy,
    output logic           rdy_oe,
    input  logic           disp_busy,
    output logic           ram_en,
    output logic           ram_we,
    output logic [RAW-1:0] ram_addr,
    output logic [1:0]     ram_be,
    output logic [DW-1:0]  ram_wdata,
    input  logic [DW-1:0]  ram_rdata,
    output logic           pal_we,
    output logic [1:0]     pal_idx,
    output logic [PW-1:0]  pal_data
);
    import tdr_pkg::*;

    typedef struct packed {
        st_e            st;
        logic           wr;
        logic [RAW-1:0] waddr;
        logic [1:0]     be;
        logic [1:0]     lanes;
        logic [DW-1:0]  wdat;
        logic [1:0]     pidx;
        logic [PW-1:0]  pdat;
        logic [DW-1:0]  rword;
    } regs_t;

    regs_t q, d;

    logic           tile_hit, pal_hit;
    logic [RAW-1:0] word_live;
    logic [1:0]     pidx_live, be_live, lanes_live;
    logic [DW-1:0]  wdat_live;
    logic [PW-1:0]  pdat_live;
    logic           rd_req, wr_req, ram_go, pal_go;

    tdr_tile_decode #(.ROWS(ROWS), .COLB(COLB), .HAW(HAW), .RAW(RAW)) u_dec (
        .addr      (host_addr),
        .pos       (pos),
        .dir       (dir),
        .tile_hit  (tile_hit),
        .word_addr (word_live),
        .pal_hit   (pal_hit),
        .pal_idx   (pidx_live)
    );

    tdr_lane_steer #(.DW(DW), .PW(PW)) u_steer (
        .bus8      (bus8),
        .a0        (host_addr[0]),
        .ube_n     (ube_n),
        .wdata     (host_wdata),
        .rword     (q.rword),
        .ram_be    (be_live),
        .bus_lanes (lanes_live),
        .ram_wdata (wdat_live),
        .rd_data   (rd_data),
        .pal_data  (pdat_live)
    );

    always_comb begin
        rd_req = !cs_n && !oe_n && we_n;
        wr_req = !cs_n && !we_n && oe_n;
        ram_go = tile_hit && (be_live != 2'b00) && (rd_req || wr_req);
        pal_go = pal_hit && wr_req && (be_live != 2'b00);

        d          = q;
        ram_en     = 1'b0;
        ram_we     = 1'b0;
        pal_we     = 1'b0;
        rdy        = 1'b0;
        rd_lane_oe = 2'b00;

        case (q.st)
            ST_IDLE: begin
                if (ram_go) begin
                    d.st    = ST_WAIT;
                    d.wr    = wr_req;
                    d.waddr = word_live;
                    d.be    = be_live;
                    d.lanes = lanes_live;
                    d.wdat  = wdat_live;
                end else if (pal_go) begin
                    d.st   = ST_PAL;
                    d.pidx = pidx_live;
                    d.pdat = pdat_live;
                end
            end
            ST_WAIT: begin
                if (!disp_busy) begin
                    ram_en = 1'b1;
                    ram_we = q.wr;
                    d.st   = q.wr ? ST_DONE : ST_CAPT;
                end
            end
            ST_CAPT: begin
                d.rword = ram_rdata;
                d.st    = ST_DONE;
            end
            ST_PAL: begin
                pal_we = 1'b1;
                d.st   = ST_DONE;
            end
            ST_DONE: begin
                rdy        = 1'b1;
                rd_lane_oe = q.wr ? 2'b00 : q.lanes;
                if (!(rd_req || wr_req)) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        rdy_oe    = (q.st != ST_IDLE);
        ram_addr  = q.waddr;
        ram_be    = q.be;
        ram_wdata = q.wdat;
        pal_idx   = q.pidx;
        pal_data  = q.pdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tdr_host_if_chk.sv
module tdr_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       bus8,
    input logic       disp_busy,
    input logic       rdy,
    input logic       rdy_oe,
    input logic [1:0] rd_lane_oe,
    input logic       ram_en,
    input logic       ram_we,
    input logic [1:0] ram_be,
    input logic       pal_we
);
    p_no_ram_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> !disp_busy);

    p_rdy_driven_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> rdy_oe);

    p_release_after_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && (cs_n || (oe_n && we_n))) |=> !rdy_oe);

    p_lanes_need_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lane_oe != 2'b00) |-> rdy);

    p_narrow_low_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus8 |-> !rd_lane_oe[1]);

    p_pal_no_ram_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> !ram_en);

    p_unselected_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_oe && cs_n) |=> !rdy_oe);

    p_write_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we) |-> (ram_be != 2'b00));

    p_pal_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> !pal_we);
endmodule

bind tdr_host_if tdr_host_if_chk u_chk (.*);

// File: tb/tdr_host_if_tb.sv
module tdr_host_if_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NWORDS = 4800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ube_n = 1'b0;
    logic        bus8 = 1'b0, dir = 1'b0, disp_busy = 1'b0;
    logic [1:0]  pos = 2'd0;
    logic [15:0] rd_data;
    logic [1:0]  rd_lane_oe;
    logic        rdy, rdy_oe, ram_en, ram_we, pal_we;
    logic [12:0] ram_addr;
    logic [1:0]  ram_be, pal_idx;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic [4:0]  pal_data;

    logic [15:0] mem [0:NWORDS-1];
    int checks = 0, bad = 0, ram_cnt = 0;
    bit pal_seen = 0;
    logic [1:0] pal_i;
    logic [4:0] pal_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdr_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .ube_n(ube_n), .bus8(bus8),
        .pos(pos), .dir(dir), .rd_data(rd_data), .rd_lane_oe(rd_lane_oe),
        .rdy(rdy), .rdy_oe(rdy_oe), .disp_busy(disp_busy), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pal_we(pal_we),
        .pal_idx(pal_idx), .pal_data(pal_data)
    );

    // behavioural single-port memory, one cycle read latency
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
                if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
            end
            ram_rdata <= mem[ram_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // per-clock monitor: memory never used under display ownership (R8), palette capture
    always @(negedge clk) begin
        if (rst_n && ram_en) begin
            ram_cnt++;
            chk(!disp_busy, "R8 ram cycle while display busy", 32'(disp_busy), 0);
        end
        if (rst_n && pal_we) begin
            pal_seen = 1;
            pal_i = pal_idx;
            pal_d = pal_data;
        end
    end

    // independent tile model: which chip owns a row/column, local index
    function automatic int ref_index(input int row, input int col, input int p, input bit dr, output bit hit);
        int rc, cc, owner;
        rc = row / 160;
        cc = col / 60;
        hit = 0;
        if (row < 320 && col < 120) begin
            owner = dr ? (rc * 2 + cc) : (cc * 2 + rc);
            hit = (owner == p);
        end
        return (row % 160) * 30 + (col % 60) / 2;
    endfunction

    task automatic access(input bit wr, input logic [16:0] a, input logic [15:0] dat,
                          input bit ube, input int busy_n, input int hold,
                          output logic [15:0] rd, output logic [1:0] ln,
                          output int edges, output bit any_oe);
        bit got;
        got = 0; any_oe = 0; rd = '0; ln = '0; edges = 0;
        pal_seen = 0;
        host_addr = a; host_wdata = dat; ube_n = ube;
        cs_n = 1'b0; oe_n = wr; we_n = !wr;
        disp_busy = (busy_n > 0);
        for (int k = 0; k < 16; k++) begin
            @(posedge clk); @(negedge clk);
            edges++;
            disp_busy = (edges < busy_n);
            if (rdy_oe) any_oe = 1;
            if (rdy_oe && rdy) begin got = 1; break; end
        end
        if (got) begin
            rd = rd_data; ln = rd_lane_oe;
            for (int h = 0; h < hold; h++) begin
                @(posedge clk); @(negedge clk);
                chk(rdy && rdy_oe && rd_data == rd && rd_lane_oe == ln,
                    "R11 ready/data held", {15'd0, rdy, rd_data}, {15'd0, 1'b1, rd});
            end
        end else edges = -1;
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; disp_busy = 1'b0;
        @(posedge clk); @(negedge clk);
        if (got) chk(!rdy_oe && rd_lane_oe == 2'b00, "R11 release after strobe drop",
                     {30'd0, rdy_oe, |rd_lane_oe}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", checks + 1, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd, old;
        logic [1:0]  ln;
        int e, idx, rc0;
        bit oe, hit;
        for (int i = 0; i < NWORDS; i++) mem[i] = 16'(i * 7 + 3);

        repeat (3) @(negedge clk);
        chk(!rdy_oe && rd_lane_oe == 0 && !ram_en, "R12 reset state", {rdy_oe, rd_lane_oe, ram_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rdy_oe && !ram_en, "R12 idle after reset", {rdy_oe, ram_en}, 0);

        // R3/R9 word write at row 5, byte column 0x10
        idx = ref_index(5, 16, 0, 0, hit);
        access(1, 17'h00510, 16'h1B4E, 0, 0, 0, rd, ln, e, oe);
        chk(e == 2, "R9 write latency", e, 2);
        chk(mem[idx] == 16'h1B4E, "R3 word write mapping", mem[idx], 16'h1B4E);
        chk(mem[idx][1:0] == 2'b10, "R3 first pixel in bits 1..0", mem[idx][1:0], 2'b10);

        access(0, 17'h00510, 16'h0, 0, 0, 2, rd, ln, e, oe);
        chk(e == 3, "R9 read latency", e, 3);
        chk(rd == 16'h1B4E && ln == 2'b11, "R3 word read", {ln, rd}, {2'b11, 16'h1B4E});

        // R4 upper-only, lower-only, none
        access(1, 17'h00511, 16'hA5FF, 0, 0, 0, rd, ln, e, oe);
        chk(mem[idx] == 16'hA54E, "R4 upper byte only", mem[idx], 16'hA54E);
        access(1, 17'h00510, 16'hFFC3, 1, 0, 0, rd, ln, e, oe);
        chk(mem[idx] == 16'hA5C3, "R4 lower byte only", mem[idx], 16'hA5C3);
        access(0, 17'h00511, 16'h0, 0, 0, 0, rd, ln, e, oe);
        chk(ln == 2'b10 && rd[15:8] == 8'hA5, "R4 upper lane read", {ln, rd}, {2'b10, 16'hA5C3});
        rc0 = ram_cnt;
        access(1, 17'h00511, 16'h9999, 1, 0, 0, rd, ln, e, oe);
        chk(e == -1 && !oe && ram_cnt == rc0 && mem[idx] == 16'hA5C3, "R4 no lane no access",
            {oe, ram_cnt[15:0]}, {1'b0, rc0[15:0]});

        // R5 8-bit bus
        bus8 = 1'b1;
        access(1, 17'h00511, 16'hFF3C, 1, 0, 0, rd, ln, e, oe);
        chk(mem[idx] == 16'h3CC3, "R5 narrow write upper byte", mem[idx], 16'h3CC3);
        access(0, 17'h00511, 16'h0, 1, 0, 0, rd, ln, e, oe);
        chk(rd == 16'h003C && ln == 2'b01, "R5 narrow read upper byte", {ln, rd}, {2'b01, 16'h003C});
        access(0, 17'h00510, 16'h0, 0, 0, 0, rd, ln, e, oe);
        chk(rd == 16'h00C3 && ln == 2'b01, "R5 narrow read lower byte", {ln, rd}, {2'b01, 16'h00C3});
        bus8 = 1'b0;

        // R7 outside tile, then R1 position 1
        idx = ref_index(160, 59, 1, 0, hit);
        old = mem[idx]; rc0 = ram_cnt;
        access(1, 17'h0A03B, 16'h7700, 0, 0, 0, rd, ln, e, oe);
        chk(!oe && ram_cnt == rc0 && mem[idx] == old, "R7 out of tile ignored", {oe, mem[idx]}, {1'b0, old});
        access(0, 17'h0A03B, 16'h0, 0, 0, 0, rd, ln, e, oe);
        chk(!oe && ln == 0, "R7 out of tile read silent", {oe, ln}, 0);
        pos = 2'd1;
        access(1, 17'h0A03B, 16'h7700, 0, 0, 0, rd, ln, e, oe);
        chk(hit && mem[idx] == {8'h77, old[7:0]}, "R1 row half by position bit 0", mem[idx], {8'h77, old[7:0]});

        // R1 column half, R2 direction swap
        pos = 2'd2;
        idx = ref_index(0, 60, 2, 0, hit);
        access(1, 17'h0003C, 16'h0012, 1, 0, 0, rd, ln, e, oe);
        chk(hit && mem[idx][7:0] == 8'h12, "R1 column half by position bit 1", mem[idx][7:0], 8'h12);
        dir = 1'b1;
        access(1, 17'h0003C, 16'h0055, 1, 0, 0, rd, ln, e, oe);
        chk(!oe && mem[idx][7:0] == 8'h12, "R2 position 2 misses when swapped", mem[idx][7:0], 8'h12);
        pos = 2'd1;
        idx = ref_index(0, 60, 1, 1, hit);
        access(1, 17'h0003C, 16'h0034, 1, 0, 0, rd, ln, e, oe);
        chk(hit && oe && mem[idx][7:0] == 8'h34, "R2 position 1 owns column half", mem[idx][7:0], 8'h34);
        dir = 1'b0; pos = 2'd0;

        // R8 contention
        idx = ref_index(7, 2, 0, 0, hit);
        access(1, 17'h00702, 16'hBEEF, 0, 4, 0, rd, ln, e, oe);
        chk(e == 5, "R8 write delayed by busy", e, 5);
        chk(mem[idx] == 16'hBEEF, "R8 write lands after busy", mem[idx], 16'hBEEF);
        access(0, 17'h00702, 16'h0, 0, 3, 1, rd, ln, e, oe);
        chk(e == 5 && rd == 16'hBEEF, "R8 read delayed by busy", {e[15:0], rd}, {16'd5, 16'hBEEF});
        access(0, 17'h00702, 16'h0, 0, 1, 0, rd, ln, e, oe);
        chk(e == 3, "R8 one busy cycle costs nothing", e, 3);

        // R10 palette
        rc0 = ram_cnt;
        access(1, 17'h1FFFD, 16'h1300, 0, 0, 0, rd, ln, e, oe);
        chk(e == 2 && pal_seen && pal_i == 2'd1 && pal_d == 5'h13 && ram_cnt == rc0,
            "R10 palette write", {e[7:0], pal_i, 1'b0, pal_d}, {8'd2, 2'd1, 1'b0, 5'h13});
        access(1, 17'h1FFF1, 16'h0007, 1, 0, 0, rd, ln, e, oe);
        chk(!oe && !pal_seen, "R10 other position palette ignored", {oe, pal_seen}, 0);

        // R6 output disable and not selected
        rc0 = ram_cnt;
        host_addr = 17'h00510; cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk(!rdy_oe && ram_cnt == rc0, "R6 output disable no transfer", {rdy_oe, ram_cnt[15:0]}, {1'b0, rc0[15:0]});
        cs_n = 1'b1; we_n = 1'b0;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk(!rdy_oe && ram_cnt == rc0, "R6 not selected no transfer", {rdy_oe, ram_cnt[15:0]}, {1'b0, rc0[15:0]});
        we_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule